// File: doc/BRIEF.md
# Test Pin Vector Sequencer

This block sits between a small set of chip test pins and an internal bus-master engine. It turns a request on the test pins into test mode entry, which means a clock switch and then bus ownership. While in test mode it classifies each vector the tester presents. It launches single write or read transfers on the engine, puts read data back on the tester's data bus, and leaves test mode cleanly when the tester asks.

The two request pins form a code `{pin_a, pin_b}`. Code 11 has three possible meanings: address, control or turnaround. The block resolves which one from context. The two vectors after a read are turnarounds. An isolated code-11 vector is an address. In a run of several code-11 vectors, the final one is a control word. Because the end of a run is only known when another code arrives, the block keeps a shadow of the previous address. When a run closes, it restores that shadow and forwards the final word on a separate control strobe. At that moment `vec_class` reports the vector that closed the run.

Top module: `tpv_sequencer`

## Requirements
- R1: After reset, `tack`, `clk_sel`, `bus_req`, `tdata_oe` and `vec_valid` are low. While `pin_a` is low in normal mode they stay low. `pin_a` high raises `clk_sel` one cycle later.
- R2: `bus_req` rises only in the cycle after `clk_is_test` is seen high. `tack` rises in the cycle after `bus_gnt` is seen high while requesting. No transfer starts without grant.
- R3: In test mode, code 10 is a write. `xfer_start` pulses for one cycle with `xfer_write`=1, `xfer_wdata` set to the sampled `tdata_in`, and `xfer_addr` set to the current address. `tack` is low from the next cycle until the cycle after `xfer_done`.
- R4: Code 01 is a read: `xfer_start` pulses with `xfer_write`=0. The cycle after `xfer_done`, `tdata_out` holds `xfer_rdata` and `tdata_oe` is high.
- R5: A code-11 vector between two other codes is reported as an address and becomes the address of later transfers.
- R6: In a run of two or more code-11 vectors, each vector is reported as an address. When another code ends the run, `ctrl_valid` pulses with `ctrl_word` equal to the final word of the run. The address used from then on is the word of the second-to-last vector of the run.
- R7: A closing control word with bit 0 low gives no `ctrl_valid`, but the address is still restored as in R6.
- R8: The two code-11 vectors after a read are turnarounds. They leave the address unchanged, and the first one drops `tdata_oe`.
- R9: Code 00 exits test mode. `bus_req` and `clk_sel` fall the next cycle. `tack` stays high until `clk_is_test` is seen low, then falls the next cycle.
- R10: Each vector accepted in test mode, other than an exit, gives a one-cycle `vec_valid` in the next cycle. `vec_class` then reads 0 for address, 1 for write, 2 for read and 3 for turnaround.
- R11: While `tack` is low during a transfer, the pins are ignored: there is no `vec_valid` and no further `xfer_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Test request pin, high bit of the code |
| pin_b | input | 1 | Test request pin, low bit of the code |
| clk_is_test | input | 1 | Clock switch reports the test clock is selected |
| clk_sel | output | 1 | Asks the clock switch for the test clock |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| tack | output | 1 | Test acknowledge / vector ready |
| tdata_in | input | DW | Tester data bus, inbound |
| tdata_out | output | DW | Tester data bus, outbound read data |
| tdata_oe | output | 1 | Output enable for the tester data bus |
| vec_valid | output | 1 | One-cycle strobe per accepted vector |
| vec_class | output | 2 | Vector class, encoded as in R10 |
| ctrl_valid | output | 1 | Strobe for a forwarded control word |
| ctrl_word | output | DW | Forwarded control word |
| xfer_start | output | 1 | Transfer launch pulse to the bus engine |
| xfer_write | output | 1 | Transfer direction, 1 = write |
| xfer_addr | output | AW | Transfer address |
| xfer_wdata | output | DW | Transfer write data |
| xfer_done | input | 1 | Bus engine finished the transfer |
| xfer_rdata | input | DW | Read data from the bus engine |

## Verification
A wrong run length or a stale shadow address shows up at the next write or read. The bench sees it on `xfer_addr` in the cycle after that vector, and also as a missing or spurious `ctrl_valid` in the same cycle. A turnaround count that is off shows on `vec_class` and `tdata_oe` one cycle after the first vector that follows a read. A mode state machine that is out of step shows within one cycle of each handshake input as a wrong `tack`, `bus_req` or `clk_sel` level.

// File: rtl/tpv_pkg.sv
package tpv_pkg;

  typedef enum logic [1:0] {
    PC_EXIT   = 2'b00,
    PC_READ   = 2'b01,
    PC_WRITE  = 2'b10,
    PC_SHARED = 2'b11
  } pin_code_e;

  typedef enum logic [1:0] {
    VC_ADDR  = 2'd0,
    VC_WRITE = 2'd1,
    VC_READ  = 2'd2,
    VC_TURN  = 2'd3
  } vec_class_e;

  typedef enum logic [2:0] {
    MS_IDLE,
    MS_SWITCH,
    MS_REQ,
    MS_READY,
    MS_BUSY,
    MS_LEAVE
  } mode_e;

  localparam int unsigned TURN_VECTORS = 2;

endpackage

// File: rtl/tpv_rst_sync.sv
module tpv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/tpv_mode_fsm.sv
module tpv_mode_fsm
  import tpv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  input  logic       clk_is_test,
  input  logic       bus_gnt,
  input  logic       xfer_done,
  output logic       take,
  output logic       launch,
  output logic       busy,
  output logic       tack,
  output logic       bus_req,
  output logic       clk_sel
);

  mode_e state_q, state_d;
  logic  leave;

  // A vector is sampled on every edge spent in the ready state.
  always_comb begin
    take   = (state_q == MS_READY);
    launch = take && ((code == PC_READ) || (code == PC_WRITE));
    leave  = take && (code == PC_EXIT);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      MS_IDLE:   if (code[1])     state_d = MS_SWITCH;
      MS_SWITCH: if (clk_is_test) state_d = MS_REQ;
      MS_REQ:    if (bus_gnt)     state_d = MS_READY;
      MS_READY: begin
        if (leave)       state_d = MS_LEAVE;
        else if (launch) state_d = MS_BUSY;
      end
      MS_BUSY:   if (xfer_done)    state_d = MS_READY;
      MS_LEAVE:  if (!clk_is_test) state_d = MS_IDLE;
      default:   state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_comb begin
    busy    = (state_q == MS_BUSY);
    tack    = (state_q == MS_READY) || (state_q == MS_LEAVE);
    bus_req = (state_q == MS_REQ) || (state_q == MS_READY) || (state_q == MS_BUSY);
    clk_sel = (state_q == MS_SWITCH) || bus_req;
  end

endmodule

// File: rtl/tpv_vec_classifier.sv
module tpv_vec_classifier
  import tpv_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [1:0]    code,
  input  logic [DW-1:0] din,
  output logic [AW-1:0] eff_addr,
  output logic          vec_valid,
  output logic [1:0]    vec_class,
  output logic          ctrl_valid,
  output logic [DW-1:0] ctrl_word
);

  localparam int unsigned TW = $clog2(TURN_VECTORS + 1);

  logic [AW-1:0] addr_q, shadow_q;
  logic [DW-1:0] last_q, ctrl_q;
  logic [1:0]    run_q;
  logic [TW-1:0] turn_q;
  logic          vv_q, cv_q;
  vec_class_e    class_q, class_d;
  logic          shared, turn_take, addr_take, other_take, run_end;

  always_comb begin
    shared     = take && (code == PC_SHARED);
    turn_take  = shared && (turn_q != '0);
    addr_take  = shared && (turn_q == '0);
    other_take = take && (code != PC_SHARED);
    run_end    = other_take && (run_q == 2'd2);
    eff_addr   = run_end ? shadow_q : addr_q;
  end

  always_comb begin
    case (code)
      PC_WRITE: class_d = VC_WRITE;
      PC_READ:  class_d = VC_READ;
      default:  class_d = turn_take ? VC_TURN : VC_ADDR;
    endcase
  end

  // Address, shadow and run length.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      shadow_q <= '0;
      last_q   <= '0;
      run_q    <= 2'd0;
    end else if (addr_take) begin
      shadow_q <= addr_q;
      addr_q   <= din[AW-1:0];
      last_q   <= din;
      run_q    <= (run_q == 2'd2) ? 2'd2 : run_q + 2'd1;
    end else if (other_take) begin
      if (run_end) addr_q <= shadow_q;
      run_q <= 2'd0;
    end
  end

  // Turnaround countdown after a read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= '0;
    end else if (take) begin
      if (turn_take)              turn_q <= turn_q - 1'b1;
      else if (code == PC_READ)   turn_q <= TW'(TURN_VECTORS);
      else if (code != PC_SHARED) turn_q <= '0;
    end
  end

  // Report strobes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vv_q    <= 1'b0;
      cv_q    <= 1'b0;
      class_q <= VC_ADDR;
      ctrl_q  <= '0;
    end else begin
      vv_q <= take && (code != PC_EXIT);
      cv_q <= run_end && last_q[0];
      if (take) class_q <= class_d;
      if (run_end) ctrl_q <= last_q;
    end
  end

  assign vec_valid  = vv_q;
  assign vec_class  = class_q;
  assign ctrl_valid = cv_q;
  assign ctrl_word  = ctrl_q;

endmodule

// File: rtl/tpv_xfer_port.sv
module tpv_xfer_port
  import tpv_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          launch,
  input  logic          busy,
  input  logic [1:0]    code,
  input  logic [AW-1:0] eff_addr,
  input  logic [DW-1:0] din,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_rdata,
  output logic          xfer_start,
  output logic          xfer_write,
  output logic [AW-1:0] xfer_addr,
  output logic [DW-1:0] xfer_wdata,
  output logic [DW-1:0] tdata_out,
  output logic          tdata_oe
);

  logic rd_cap;

  assign rd_cap = busy && xfer_done && !xfer_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_start <= 1'b0;
      xfer_write <= 1'b0;
      xfer_addr  <= '0;
      xfer_wdata <= '0;
    end else begin
      xfer_start <= launch;
      if (launch) begin
        xfer_write <= (code == PC_WRITE);
        xfer_addr  <= eff_addr;
        xfer_wdata <= din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdata_out <= '0;
      tdata_oe  <= 1'b0;
    end else begin
      if (rd_cap) tdata_out <= xfer_rdata;
      if (rd_cap)                             tdata_oe <= 1'b1;
      else if (take && (code != PC_READ))     tdata_oe <= 1'b0;
    end
  end

endmodule

// File: rtl/tpv_sequencer.sv
module tpv_sequencer
  import tpv_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_a,
  input  logic          pin_b,
  input  logic          clk_is_test,
  output logic          clk_sel,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          tack,
  input  logic [DW-1:0] tdata_in,
  output logic [DW-1:0] tdata_out,
  output logic          tdata_oe,
  output logic          vec_valid,
  output logic [1:0]    vec_class,
  output logic          ctrl_valid,
  output logic [DW-1:0] ctrl_word,
  output logic          xfer_start,
  output logic          xfer_write,
  output logic [AW-1:0] xfer_addr,
  output logic [DW-1:0] xfer_wdata,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_rdata
);

  logic          rst_n_int;
  logic [1:0]    code;
  logic          take, launch, busy;
  logic [AW-1:0] eff_addr;

  assign code = {pin_a, pin_b};

  tpv_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tpv_mode_fsm u_mode (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .code        (code),
    .clk_is_test (clk_is_test),
    .bus_gnt     (bus_gnt),
    .xfer_done   (xfer_done),
    .take        (take),
    .launch      (launch),
    .busy        (busy),
    .tack        (tack),
    .bus_req     (bus_req),
    .clk_sel     (clk_sel)
  );

  tpv_vec_classifier #(.AW(AW), .DW(DW)) u_class (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .take       (take),
    .code       (code),
    .din        (tdata_in),
    .eff_addr   (eff_addr),
    .vec_valid  (vec_valid),
    .vec_class  (vec_class),
    .ctrl_valid (ctrl_valid),
    .ctrl_word  (ctrl_word)
  );

  tpv_xfer_port #(.AW(AW), .DW(DW)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .take       (take),
    .launch     (launch),
    .busy       (busy),
    .code       (code),
    .eff_addr   (eff_addr),
    .din        (tdata_in),
    .xfer_done  (xfer_done),
    .xfer_rdata (xfer_rdata),
    .xfer_start (xfer_start),
    .xfer_write (xfer_write),
    .xfer_addr  (xfer_addr),
    .xfer_wdata (xfer_wdata),
    .tdata_out  (tdata_out),
    .tdata_oe   (tdata_oe)
  );

endmodule

// File: rtl/tpv_sequencer_chk.sv
module tpv_sequencer_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tack,
  input logic          clk_sel,
  input logic          clk_is_test,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          xfer_start,
  input logic          xfer_write,
  input logic          xfer_done,
  input logic          tdata_oe,
  input logic          vec_valid,
  input logic [1:0]    vec_class,
  input logic          ctrl_valid,
  input logic [DW-1:0] ctrl_word
);

  AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_sel && !tack) |-> (!bus_req && !xfer_start)); // R1

  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (bus_req && bus_gnt)); // R2

  AST_ACK_AFTER_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tack) |-> $past(clk_is_test)); // R2

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start); // R3

  AST_ACK_LOW_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !tack); // R3

  AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdata_oe) |-> ($past(xfer_done) && !$past(xfer_write))); // R4

  AST_CTRL_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_valid |-> ctrl_word[0]); // R7

  AST_TURN_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && (vec_class == 2'd3)) |-> !tdata_oe); // R8

  AST_EXIT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_sel) |-> !bus_req); // R9

  AST_NO_REPORT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !tack) |=> !vec_valid); // R11

endmodule

bind tpv_sequencer tpv_sequencer_chk #(.DW(DW)) u_chk (.*);

// File: tb/tpv_sequencer_test.sv
module tpv_sequencer_test;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic pin_a, pin_b, clk_is_test, bus_gnt, xfer_done;
  logic [DW-1:0] tdata_in, xfer_rdata, tdata_out, ctrl_word, xfer_wdata;
  logic [AW-1:0] xfer_addr;
  logic clk_sel, bus_req, tack, tdata_oe, vec_valid, ctrl_valid, xfer_start, xfer_write;
  logic [1:0] vec_class;

  always #5 clk = ~clk;

  tpv_sequencer #(.AW(AW), .DW(DW)) uut (.*);

  typedef struct { logic [1:0] cls; string req; } vexp_t;
  typedef struct { logic w; logic [31:0] addr; logic [31:0] data; string req; } xexp_t;
  typedef struct { logic [31:0] word; string req; } cexp_t;

  vexp_t vq[$];
  xexp_t xq[$];
  cexp_t cq[$];
  vexp_t ve;
  xexp_t xe;
  cexp_t ce;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] rd_value = '0;

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_vec(logic [1:0] cls, string req);
    vq.push_back('{cls, req});
  endtask

  task automatic exp_xfer(logic w, logic [31:0] a, logic [31:0] d, string req);
    xq.push_back('{w, a, d, req});
  endtask

  task automatic exp_ctrl(logic [31:0] word, string req);
    cq.push_back('{word, req});
  endtask

  // Present one vector; on a transfer, scramble the pins while busy (R11).
  task automatic send(logic a, logic b, logic [31:0] d);
    pin_a = a; pin_b = b; tdata_in = d;
    @(posedge clk); @(negedge clk);
    if (a != b) begin
      pin_a = 1'b1; pin_b = 1'b1; tdata_in = 32'hBAD0_BAD0;
      check_eq("R3", "tack during transfer", tack, 1'b0);
      while (!tack) @(negedge clk);
    end
  endtask

  // Bus engine model.
  initial begin
    xfer_done = 1'b0; xfer_rdata = '0;
    forever begin
      @(negedge clk);
      if (xfer_start) begin
        repeat (2) @(negedge clk);
        xfer_rdata = rd_value; xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
      end
    end
  end

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (vec_valid) begin
        if (vq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R11 unexpected vector actual=%0d expected=none", vec_class);
        end else begin
          ve = vq.pop_front();
          check_eq(ve.req, "vec_class", vec_class, ve.cls);
        end
      end
      if (xfer_start) begin
        if (xq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R11 unexpected transfer actual=%0h expected=none", xfer_addr);
        end else begin
          xe = xq.pop_front();
          check_eq(xe.req, "xfer_write", xfer_write, xe.w);
          check_eq(xe.req, "xfer_addr", xfer_addr, xe.addr);
          if (xe.w) check_eq(xe.req, "xfer_wdata", xfer_wdata, xe.data);
        end
      end
      if (ctrl_valid) begin
        if (cq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R7 unexpected control actual=%0h expected=none", ctrl_word);
        end else begin
          ce = cq.pop_front();
          check_eq(ce.req, "ctrl_word", ctrl_word, ce.word);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL R3 watchdog actual=hung expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_a = 1'b0; pin_b = 1'b0; clk_is_test = 1'b0;
    bus_gnt = 1'b0; tdata_in = '0;
    repeat (3) @(negedge clk);
    check_eq("R1", "reset tack", tack, 1'b0);
    check_eq("R1", "reset clk_sel", clk_sel, 1'b0);
    check_eq("R1", "reset bus_req", bus_req, 1'b0);
    check_eq("R1", "reset tdata_oe", tdata_oe, 1'b0);
    check_eq("R1", "reset vec_valid", vec_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1", "idle clk_sel", clk_sel, 1'b0);

    // Entry handshake.
    pin_a = 1'b1; pin_b = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R1", "clk_sel after request", clk_sel, 1'b1);
    check_eq("R2", "bus_req before clock switch", bus_req, 1'b0);
    @(posedge clk); @(negedge clk);
    check_eq("R2", "bus_req still waiting", bus_req, 1'b0);
    clk_is_test = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R2", "bus_req after switch", bus_req, 1'b1);
    check_eq("R2", "tack before grant", tack, 1'b0);
    @(posedge clk); @(negedge clk);
    check_eq("R2", "tack without grant", tack, 1'b0);
    bus_gnt = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R2", "tack after grant", tack, 1'b1);

    // R5: isolated address then write (R3, R10).
    exp_vec(2'd0, "R5"); send(1, 1, 32'h0000_1000);
    exp_vec(2'd1, "R10"); exp_xfer(1'b1, 32'h1000, 32'h0000_AAAA, "R3");
    send(1, 0, 32'h0000_AAAA);

    // R6: two-vector run closed by a read (R4).
    exp_vec(2'd0, "R6"); send(1, 1, 32'h0000_2000);
    exp_vec(2'd0, "R6"); send(1, 1, 32'h0000_0093);
    rd_value = 32'hDEAD_BEEF;
    exp_vec(2'd2, "R10"); exp_ctrl(32'h0000_0093, "R6"); exp_xfer(1'b0, 32'h2000, '0, "R6");
    send(0, 1, 32'h0);
    check_eq("R4", "tdata_oe after read", tdata_oe, 1'b1);
    check_eq("R4", "tdata_out after read", tdata_out, 32'hDEAD_BEEF);

    // R8: two turnarounds, address kept.
    exp_vec(2'd3, "R8"); send(1, 1, 32'h0000_5555);
    check_eq("R8", "tdata_oe at first turnaround", tdata_oe, 1'b0);
    exp_vec(2'd3, "R8"); send(1, 1, 32'h0000_6666);
    exp_vec(2'd1, "R8"); exp_xfer(1'b1, 32'h2000, 32'h0000_0077, "R8");
    send(1, 0, 32'h0000_0077);

    // R7: control word with bit 0 low.
    exp_vec(2'd0, "R7"); send(1, 1, 32'h0000_3000);
    exp_vec(2'd0, "R7"); send(1, 1, 32'h0000_0092);
    exp_vec(2'd1, "R7"); exp_xfer(1'b1, 32'h3000, 32'h0000_00BB, "R7");
    send(1, 0, 32'h0000_00BB);
    check_eq("R7", "no pending control", cq.size(), 0);

    // R6: three-vector run, then a read burst.
    exp_vec(2'd0, "R6"); send(1, 1, 32'h0000_4000);
    exp_vec(2'd0, "R6"); send(1, 1, 32'h0000_4100);
    exp_vec(2'd0, "R6"); send(1, 1, 32'h0000_0F01);
    rd_value = 32'h0000_1234;
    exp_vec(2'd2, "R6"); exp_ctrl(32'h0000_0F01, "R6"); exp_xfer(1'b0, 32'h4100, '0, "R6");
    send(0, 1, 32'h0);
    check_eq("R4", "first burst read data", tdata_out, 32'h0000_1234);
    rd_value = 32'h0000_5678;
    exp_vec(2'd2, "R4"); exp_xfer(1'b0, 32'h4100, '0, "R4");
    send(0, 1, 32'h0);
    check_eq("R4", "second burst read data", tdata_out, 32'h0000_5678);
    check_eq("R4", "tdata_oe in burst", tdata_oe, 1'b1);
    exp_vec(2'd3, "R8"); send(1, 1, 32'h0);
    exp_vec(2'd3, "R8"); send(1, 1, 32'h0);

    // R9: exit.
    send(0, 0, 32'h0);
    check_eq("R9", "bus_req after exit", bus_req, 1'b0);
    check_eq("R9", "clk_sel after exit", clk_sel, 1'b0);
    check_eq("R9", "tack held on exit", tack, 1'b1);
    @(posedge clk); @(negedge clk);
    check_eq("R9", "tack until clock returns", tack, 1'b1);
    clk_is_test = 1'b0; bus_gnt = 1'b0;
    @(posedge clk); @(negedge clk);
    check_eq("R9", "tack after clock returns", tack, 1'b0);
    @(posedge clk); @(negedge clk);
    check_eq("R9", "idle clk_sel after exit", clk_sel, 1'b0);

    check_eq("R10", "vectors left", vq.size(), 0);
    check_eq("R3", "transfers left", xq.size(), 0);
    check_eq("R6", "controls left", cq.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule